// File: doc/BRIEF.md
# Vector Narrowing Right Shifter

This unit takes a wide data vector and a vector of per-element shift amounts, shifts every source element right by its own amount, and keeps only the low half of each shifted element. The source vector is split into independent 128-bit lanes. Each lane packs its narrowed results densely into the lower 64 bits of the same lane and clears the upper 64 bits. Results are not packed contiguously across the whole vector.

A two-bit size select picks one of three source/result width pairs. A mode bit chooses a logical shift, which fills with zeros, or an arithmetic shift, which copies the sign bit. A width bit chooses between processing both lanes of the 256-bit vector or only the lowest lane. The operands and selects are sampled together with an input strobe into one output register. The result and its valid flag appear one clock later.

Top module: `vnarrow_shift`

## Requirements
- R1: `size_sel` encodes the width pair as 0 = 16-bit source to 8-bit result, 1 = 32 to 16, and 2 = 64 to 32. The value 3 yields an all-zero result.
- R2: In each processed lane i, the source element j (bits i*128 + j*W upward, W bits wide) produces the result element at bits i*128 + j*W/2 upward, W/2 bits wide. This fills bits 63:0 of the lane in element order.
- R3: Bits 127:64 of every 128-bit lane of the result are zero.
- R4: The shift amount of an element is the element at the same position in `src_shamt`, read as unsigned and reduced modulo W. Amounts of 0, W-1, and values of W or more therefore behave as that residue.
- R5: When `arith` is 0, the source element is unsigned and zeros enter from the top.
- R6: When `arith` is 1, the source element is signed and its top bit is replicated into the vacated positions.
- R7: Each shifted value is truncated to its low W/2 bits, with no saturation or rounding.
- R8: When `wide` is 1, both 128-bit lanes are processed. When `wide` is 0, only lane 0 is processed and result bits 255:128 are zero.
- R9: A result is captured only when `in_valid` is high and appears together with `out_valid` exactly one cycle later. When `in_valid` is low, `out_valid` drops and `result` holds its previous value.
- R10: After a synchronous reset, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| src_data | input | 256 | Wide source elements |
| src_shamt | input | 256 | Per-element shift amounts |
| size_sel | input | 2 | Width pair select |
| arith | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| wide | input | 1 | 1 = two lanes, 0 = lane 0 only |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 256 | Narrowed, lane-packed result |

## Verification
A wrong lane mux or a misplaced element slice shows up as a misplaced or corrupted half-width field in the very next result after the strobe. A broken sign-fill shows up only when a negative element is shifted by a nonzero amount in arithmetic mode. A bad modulo reduction shows up only for amounts of W or more. Because there is only one register stage, every such fault appears one cycle after the operands that trigger it. The sweep therefore covers every size, mode and width combination against an arithmetic model. It includes directed amounts of 0, W-1 and values past W, together with negative data.

// File: rtl/vns_pkg.sv
package vns_pkg;
  typedef enum logic [1:0] {
    NS_16TO8  = 2'd0,
    NS_32TO16 = 2'd1,
    NS_64TO32 = 2'd2,
    NS_NONE   = 2'd3
  } ns_size_t;

  localparam int NS_NUM_SIZES = 3;
  localparam int NS_MIN_W     = 16;
endpackage

// File: rtl/vns_elem_shift.sv
module vns_elem_shift #(
  parameter int W = 16
) (
  input  logic [W-1:0]   elem,
  input  logic [W-1:0]   amount,
  input  logic           arith,
  output logic [W/2-1:0] narrowed
);
  localparam int SHW = $clog2(W);
  localparam int HW  = W / 2;

  logic [SHW-1:0] sh;
  logic [W:0]     ext;

  assign sh  = SHW'(amount % W);
  assign ext = {arith & elem[W-1], elem};

  always_comb begin
    narrowed = HW'($signed(ext) >>> sh);
  end
endmodule

// File: rtl/vns_lane.sv
module vns_lane
  import vns_pkg::*;
#(
  parameter int LANE_W = 128
) (
  input  logic [LANE_W-1:0] lane_data,
  input  logic [LANE_W-1:0] lane_amt,
  input  ns_size_t          size,
  input  logic              arith,
  output logic [LANE_W-1:0] lane_out
);
  localparam int HALF = LANE_W / 2;

  logic [NS_NUM_SIZES-1:0][HALF-1:0] packed_r;

  for (genvar g = 0; g < NS_NUM_SIZES; g++) begin : g_size
    localparam int W = NS_MIN_W << g;
    localparam int N = LANE_W / W;
    for (genvar e = 0; e < N; e++) begin : g_elem
      vns_elem_shift #(.W(W)) u_sh (
        .elem     (lane_data[e*W +: W]),
        .amount   (lane_amt[e*W +: W]),
        .arith    (arith),
        .narrowed (packed_r[g][e*(W/2) +: W/2])
      );
    end
  end

  always_comb begin
    case (size)
      NS_16TO8:  lane_out = {{HALF{1'b0}}, packed_r[0]};
      NS_32TO16: lane_out = {{HALF{1'b0}}, packed_r[1]};
      NS_64TO32: lane_out = {{HALF{1'b0}}, packed_r[2]};
      default:   lane_out = '0;
    endcase
  end
endmodule

// File: rtl/vnarrow_shift.sv
module vnarrow_shift
  import vns_pkg::*;
#(
  parameter int VLEN   = 256,
  parameter int LANE_W = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [VLEN-1:0] src_data,
  input  logic [VLEN-1:0] src_shamt,
  input  logic [1:0]      size_sel,
  input  logic            arith,
  input  logic            wide,
  output logic            out_valid,
  output logic [VLEN-1:0] result
);
  localparam int NLANE = VLEN / LANE_W;
  localparam int HALF  = LANE_W / 2;

  ns_size_t        size;
  logic [VLEN-1:0] next_res;

  assign size = ns_size_t'(size_sel);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] lq;
    logic              en;
    vns_lane #(.LANE_W(LANE_W)) u_lane (
      .lane_data (src_data[i*LANE_W +: LANE_W]),
      .lane_amt  (src_shamt[i*LANE_W +: LANE_W]),
      .size      (size),
      .arith     (arith),
      .lane_out  (lq)
    );
    assign en = wide || (i == 0);
    assign next_res[i*LANE_W +: LANE_W] = en ? lq : '0;

    // R3
    lane_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> result[i*LANE_W+HALF +: HALF] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // R8
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide) |=> result[VLEN-1:LANE_W] == '0);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R1
  bad_size_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'd3) |=> result == '0);
endmodule

// File: tb/vnarrow_shift_test.sv
`timescale 1ns/1ps
module vnarrow_shift_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [255:0] src_data, src_shamt;
  logic [1:0]   size_sel;
  logic         arith, wide;
  logic         out_valid;
  logic [255:0] result;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  vnarrow_shift uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_data(src_data),
    .src_shamt(src_shamt), .size_sel(size_sel), .arith(arith), .wide(wide),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [255:0] model(logic [255:0] d, logic [255:0] a,
                                         int sz, logic ar, logic wd);
    logic [255:0] res = '0;
    if (sz == 3) return res;
    begin
      int w = 16 << sz;
      int nl = wd ? 2 : 1;
      logic [63:0] mask  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
      logic [63:0] hmask = (64'd1 << (w/2)) - 1;
      for (int ln = 0; ln < nl; ln++) begin
        for (int j = 0; j < 128 / w; j++) begin
          logic [63:0] x, s, r;
          int base = ln*128 + j*w;
          x = 64'(d >> base) & mask;
          s = 64'(a >> base) & mask;
          if (ar && x[w-1]) x = x | ~mask;
          if (ar) r = 64'($signed(x) >>> (s % w));
          else    r = x >> (s % w);
          res = res | (256'(r & hmask) << (ln*128 + j*(w/2)));
        end
      end
    end
    return res;
  endfunction

  function automatic logic [255:0] fill(int sz, logic [63:0] v);
    logic [255:0] o = '0;
    int w = (sz == 3) ? 16 : (16 << sz);
    for (int k = 0; k < 256 / w; k++)
      o = o | (256'(v & ((w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1))) << (k*w));
    return o;
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [255:0] d, logic [255:0] a, int sz, logic ar,
                       logic wd, string tag);
    logic [255:0] exp = model(d, a, sz, ar, wd);
    logic [255:0] held;
    @(negedge clk);
    src_data = d; src_shamt = a; size_sel = 2'(sz); arith = ar; wide = wd;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(result == exp, tag, result, exp);
    check(out_valid == 1'b1, "R9 out_valid after strobe", 256'(out_valid), 256'd1);
    held = result;
    src_data = ~d; src_shamt = a + 1;
    @(negedge clk);
    check(result == held && out_valid == 1'b0, "R9 hold without strobe", result, held);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; src_data = '0; src_shamt = '0;
    size_sel = '0; arith = 1'b0; wide = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && result == '0, "R10 reset state", result, '0);
    rst = 1'b0;

    for (int sz = 0; sz < 4; sz++) begin
      int w = (sz == 3) ? 16 : (16 << sz);
      for (int ar = 0; ar < 2; ar++) begin
        for (int wd = 0; wd < 2; wd++) begin
          // R2 R3 R5 R6 R7 R8: random data and amounts
          for (int p = 0; p < 4; p++)
            apply(rnd256(), rnd256(), sz, ar[0], wd[0], "R2/R5/R6/R7/R8 random");
          // R4: zero amount gives plain truncation
          apply(rnd256(), '0, sz, ar[0], wd[0], "R4 R7 shift by zero");
          // R4 R6: amount W-1 on negative data
          apply(fill(sz, 64'h8000_0000_0000_0000 >> (64 - w)) | rnd256() & fill(sz, 64'h7),
                fill(sz, 64'(w - 1)), sz, ar[0], wd[0], "R4 R6 shift by W-1 negative");
          // R4: amounts of W and above wrap
          apply(rnd256(), fill(sz, 64'(w + 3)) | fill(sz, 64'(w * 5)) & fill(sz, 64'h0),
                sz, ar[0], wd[0], "R4 modulo amount");
          // R1 R6: all-ones negative data
          apply({256{1'b1}}, rnd256(), sz, ar[0], wd[0], "R1 R6 all ones");
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule